// File: doc/BRIEF.md
# Re-encode-and-compare Channel Error Estimator

This block measures how often the channel corrupts coded bits behind a convolutional decoder, and it needs no known test sequence to do it. Every decoded bit goes back through a copy of the transmit encoder. Each regenerated coded bit is then compared with the sign of the received soft symbol it came from. A disagreement counts as one channel error. Symbols that were punctured and arrive as all-zero "erased" values are left out of the comparison.

The received symbols reach the block already delayed to line up with the decoded bit of the same beat. Errors add up in a running counter. A window controller counts decoded beats against a programmable period, which can be up to 24 bits wide. On the last beat of a window, the controller copies that window's total into a result register and starts a new window at once from zero.

The controller has two states:
- `ST_HOLD`: windowing is off because the period is zero.
- `ST_MEASURE`: windows are being counted.

It has two transitions:
- Arm (`ST_HOLD` to `ST_MEASURE`): taken on the clock edge after the period becomes nonzero.
- Disarm (`ST_MEASURE` to `ST_HOLD`): taken on the edge after the period returns to zero.

Top module: `ber_estimator`

## Requirements
- R1: An active-low asynchronous reset clears the running count and the window result to 0, clears the encoder history to all zeros, and puts the controller in `ST_HOLD`.
- R2: The regenerated coded bit j is the XOR of `{dec_bit, history}` masked by `POLY[j]`. Bit K-1 of that vector is the current decoded bit, and the bits below it are older decoded bits, newest first. Coded bit j is compared with received symbol j, which sits at `rx_sym[(N-j)*SW-1 -: SW]`, so symbol 0 is in the most significant bits.
- R3: The hard decision of a symbol is its most significant bit, where 1 means a coded 1. Each non-erased symbol whose hard decision differs from its regenerated bit adds exactly one error.
- R4: A symbol whose bits are all zero is erased and never counts as an error.
- R5: While `dec_valid` is low, neither the counts nor the encoder history change, whatever is on `dec_bit` and `rx_sym`.
- R6: After each clock edge with `dec_valid` high that does not close a window, `err_run` grows by that beat's error count.
- R7: In `ST_MEASURE`, the beat that brings the window's beat count to `period` closes the window. On that beat, `err_last` takes the running count plus that beat's errors, and `err_run` becomes 0.
- R8: Both `err_run` and `err_last` saturate at 65535 and never wrap.
- R9: While `period` is zero, the controller is in `ST_HOLD`. No window ever closes, `err_run` keeps accumulating, and `err_last` holds its value.
- R10: A nonzero `period` arms `ST_MEASURE` one clock later, with the window position starting at zero. A zero `period` in `ST_MEASURE` disarms the controller, clears the position and keeps both counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_valid | input | 1 | Decoded bit and symbols are valid this cycle |
| dec_bit | input | 1 | Decoded data bit |
| rx_sym | input | N*SW | Aligned received soft symbols, symbol 0 in the MSBs |
| period | input | 24 | Window length in decoded beats; 0 disables windowing |
| err_run | output | 16 | Running error count of the current window |
| err_last | output | 16 | Error count of the last completed window |

## Verification
A corrupted encoder history shows up on the first valid beat after the fault. Regenerated bits that should match start to mismatch, and `err_run` rises on the next clock edge even though the bench sends clean symbols. A wrong window position or a stuck controller state appears as `err_last` loading one beat early or late, or not at all; this is visible within a single window of `period` beats. A counter that wraps rather than saturating drops to a small value right after the 65535 boundary.

// File: rtl/ber_est_pkg.sv
package ber_est_pkg;

    typedef enum logic {
        ST_HOLD    = 1'b0,
        ST_MEASURE = 1'b1
    } win_state_t;

endpackage

// File: rtl/ber_reencoder.sv
module ber_reencoder #(
    parameter int N = 2,
    parameter int K = 7,
    parameter logic [N-1:0][K-1:0] POLY = {7'b1011011, 7'b1111001}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  logic         bit_in,
    output logic [N-1:0] coded
);

    localparam int HW = K - 1;

    logic [HW-1:0] history;
    logic [K-1:0]  taps_in;

    assign taps_in = {bit_in, history};

    generate
        for (genvar j = 0; j < N; j++) begin : g_gen
            assign coded[j] = ^(taps_in & POLY[j]);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            history <= '0;
        end else if (advance) begin
            history <= taps_in[K-1:1];
        end
    end

endmodule

// File: rtl/ber_compare.sv
module ber_compare #(
    parameter int N  = 2,
    parameter int SW = 4,
    localparam int EW = $clog2(N + 1)
) (
    input  logic [N*SW-1:0] rx_sym,
    input  logic [N-1:0]    coded,
    output logic [EW-1:0]   errs
);

    logic [N-1:0] miss;

    generate
        for (genvar j = 0; j < N; j++) begin : g_cmp
            logic [SW-1:0] sym;
            assign sym     = rx_sym[(N-j)*SW-1 -: SW];
            assign miss[j] = (sym != '0) && (sym[SW-1] != coded[j]);
        end
    endgenerate

    always_comb begin
        errs = '0;
        for (int j = 0; j < N; j++) begin
            errs = errs + EW'(miss[j]);
        end
    end

endmodule

// File: rtl/ber_window.sv
module ber_window
    import ber_est_pkg::*;
#(
    parameter int PW = 24,
    parameter int CW = 16,
    parameter int EW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat,
    input  logic [EW-1:0] errs,
    input  logic [PW-1:0] period,
    output logic [CW-1:0] err_run,
    output logic [CW-1:0] err_last,
    output logic          win_end,
    output win_state_t    state
);

    win_state_t    state_nx;
    logic [PW-1:0] pos;
    logic [CW:0]   sum;
    logic [CW-1:0] sum_sat;

    assign sum     = {1'b0, err_run} + (CW+1)'(errs);
    assign sum_sat = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HOLD:    if (period != '0) state_nx = ST_MEASURE;
            ST_MEASURE: if (period == '0) state_nx = ST_HOLD;
            default:    state_nx = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nx;
    end

    always_comb begin
        win_end = 1'b0;
        unique case (state)
            ST_HOLD:    win_end = 1'b0;
            ST_MEASURE: win_end = beat && (period != '0) &&
                                  (({1'b0, pos} + 1'b1) >= {1'b0, period});
            default:    win_end = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos      <= '0;
            err_run  <= '0;
            err_last <= '0;
        end else begin
            if (state != ST_MEASURE || win_end) pos <= '0;
            else if (beat)                      pos <= pos + 1'b1;
            if (beat) begin
                if (win_end) begin
                    err_last <= sum_sat;
                    err_run  <= '0;
                end else begin
                    err_run  <= sum_sat;
                end
            end
        end
    end

endmodule

// File: rtl/ber_estimator.sv
module ber_estimator
    import ber_est_pkg::*;
#(
    parameter int N  = 2,
    parameter int K  = 7,
    parameter int SW = 4,
    parameter int PW = 24,
    parameter int CW = 16,
    parameter logic [N-1:0][K-1:0] POLY = {7'b1011011, 7'b1111001}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic          dec_bit,
    input  logic [N*SW-1:0] rx_sym,
    input  logic [PW-1:0] period,
    output logic [CW-1:0] err_run,
    output logic [CW-1:0] err_last
);

    localparam int EW = $clog2(N + 1);

    logic [N-1:0]  coded;
    logic [EW-1:0] errs;
    logic          win_end;
    win_state_t    state;

    ber_reencoder #(.N(N), .K(K), .POLY(POLY)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (dec_valid),
        .bit_in  (dec_bit),
        .coded   (coded)
    );

    ber_compare #(.N(N), .SW(SW)) u_cmp (
        .rx_sym (rx_sym),
        .coded  (coded),
        .errs   (errs)
    );

    ber_window #(.PW(PW), .CW(CW), .EW(EW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat     (dec_valid),
        .errs     (errs),
        .period   (period),
        .err_run  (err_run),
        .err_last (err_last),
        .win_end  (win_end),
        .state    (state)
    );

endmodule

// File: rtl/ber_estimator_chk.sv
module ber_estimator_chk
    import ber_est_pkg::*;
#(
    parameter int N  = 2,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dec_valid,
    input logic [CW-1:0] err_run,
    input logic [CW-1:0] err_last,
    input logic          win_end,
    input win_state_t    state
);

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |=> ($stable(err_run) && $stable(err_last))); // R5

    AST_WIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (err_run == '0)); // R7

    AST_RUN_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !win_end) |=> (err_run >= $past(err_run))); // R6

    AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !win_end) |=> (int'(err_run) <= int'($past(err_run)) + N)); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !win_end && err_run == {CW{1'b1}}) |=> (err_run == {CW{1'b1}})); // R8

    AST_HOLD_KEEPS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> $stable(err_last)); // R9

endmodule

bind ber_estimator ber_estimator_chk #(.N(N), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_valid (dec_valid),
    .err_run   (err_run),
    .err_last  (err_last),
    .win_end   (win_end),
    .state     (state)
);

// File: tb/ber_estimator_tb.sv
module ber_estimator_tb;

    localparam int N  = 2;
    localparam int K  = 7;
    localparam int SW = 4;
    localparam int PW = 24;
    localparam int CW = 16;
    localparam logic [N-1:0][K-1:0] POLY = {7'b1011011, 7'b1111001};
    localparam logic [SW-1:0] NEG = 4'b1011;
    localparam logic [SW-1:0] POS = 4'b0101;

    // entry: {bit, flipA, flipB, eraseA, eraseB}
    localparam int NV = 16;
    localparam logic [4:0] VEC [NV] = '{
        5'b10000, 5'b01000, 5'b11100, 5'b00010,
        5'b01010, 5'b10110, 5'b00101, 5'b11000,
        5'b00000, 5'b00100, 5'b10011, 5'b01111,
        5'b11100, 5'b00000, 5'b10100, 5'b01000
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            dec_valid = 1'b0;
    logic            dec_bit = 1'b0;
    logic [N*SW-1:0] rx_sym = '0;
    logic [PW-1:0]   period = '0;
    logic [CW-1:0]   err_run;
    logic [CW-1:0]   err_last;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ber_estimator #(.N(N), .K(K), .SW(SW), .PW(PW), .CW(CW), .POLY(POLY)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_valid (dec_valid),
        .dec_bit   (dec_bit),
        .rx_sym    (rx_sym),
        .period    (period),
        .err_run   (err_run),
        .err_last  (err_last)
    );

    // reference model built from the requirements
    logic [K-2:0]  m_hist;
    int            m_run, m_last, m_pos;
    bit            m_meas;

    function automatic int sat(input int v);
        return (v > 65535) ? 65535 : v;
    endfunction

    function automatic logic model_coded(input int j, input logic b);
        return ^({b, m_hist} & POLY[j]);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_hist = '0; m_run = 0; m_last = 0; m_pos = 0; m_meas = 0;
        end else begin
            if (dec_valid) begin
                int e;
                logic [SW-1:0] s;
                e = 0;
                for (int j = 0; j < N; j++) begin
                    s = rx_sym[(N-j)*SW-1 -: SW];
                    if (s != '0 && s[SW-1] != model_coded(j, dec_bit)) e++;
                end
                if (m_meas && period != 0 && m_pos + 1 >= int'(period)) begin
                    m_last = sat(m_run + e);
                    m_run  = 0;
                    m_pos  = 0;
                end else begin
                    m_run = sat(m_run + e);
                    if (m_meas) m_pos++;
                end
                m_hist = {dec_bit, m_hist[K-2:1]};
            end
            if (!m_meas) m_pos = 0;
            m_meas = (period != 0);
        end
    end

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive one beat at a falling edge from a table entry
    task automatic drive(input logic [4:0] v);
        logic [SW-1:0] sa, sb;
        sa = (model_coded(0, v[4]) ^ v[3]) ? NEG : POS;
        sb = (model_coded(1, v[4]) ^ v[2]) ? NEG : POS;
        if (v[1]) sa = '0;
        if (v[0]) sb = '0;
        dec_bit   = v[4];
        rx_sym    = {sa, sb};
        dec_valid = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int keep;
        period = 24'd5;
        repeat (3) @(negedge clk);
        check(err_run, 0, "R1 run after reset");
        check(err_last, 0, "R1 last after reset");
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2 R3 R4 R6 R7
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            dec_valid = 1'b0;
            check(err_run, m_run, "R2/R3/R4/R6 run");
            check(err_last, m_last, "R7 last");
        end
        check(err_last, 3, "R7 third window total");

        // R5: idle inputs ignored
        keep = err_run;
        dec_bit = 1'b1; rx_sym = {NEG, NEG}; dec_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(err_run, keep, "R5 run frozen");
        drive(5'b00000);
        @(negedge clk);
        dec_valid = 1'b0;
        check(err_run, keep, "R5 encoder history untouched");

        // R9: period zero holds result
        period = '0;
        repeat (2) @(negedge clk);
        keep = err_last;
        for (int i = 0; i < 6; i++) begin
            drive(5'b11100);
            @(negedge clk);
            dec_valid = 1'b0;
        end
        check(err_last, keep, "R9 last held");
        check(err_run, m_run, "R9 run accumulates");

        // R10: arm with period 3
        period = 24'd3;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            drive(5'b01000);
            @(negedge clk);
            dec_valid = 1'b0;
            check(err_last, m_last, "R10 last");
        end
        check(err_run, 0, "R10 window closed");

        // R8: saturation
        rst_n = 1'b0;
        period = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        dec_bit = 1'b0; rx_sym = {NEG, NEG}; dec_valid = 1'b1;
        repeat (32770) @(negedge clk);
        dec_valid = 1'b0;
        check(err_run, 65535, "R8 run saturates");
        period = 24'd1;
        @(negedge clk);
        dec_valid = 1'b1;
        @(negedge clk);
        dec_valid = 1'b0;
        check(err_last, 65535, "R8 last saturates");
        check(err_run, 0, "R8 run cleared at window");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule